// File: doc/BRIEF.md
# Legacy System I/O Register Block

This block sits on a byte-wide, strobe-based port I/O bus and answers a small, scattered set of fixed 16-bit port addresses. It keeps three pieces of live state: a soft-reset flag, a system-control byte and an I/O-map-type flag. It returns two board-strapped bytes (equipment and board identity) and a keylock byte that always reads zero. It also takes writes to four write-only ports, which change nothing. Two outputs are driven from the stored state: a soft-reset line and a non-contiguous-map line. A third output, a sticky error flag, reports any request for little-endian operation. That mode is not supported and is never stored.

Fields use reversed bit numbering: logical bit n is data bit (7-n). Logical bit 7 is therefore the least significant data bit. The block also serves a 4-byte memory-mapped parity-error window that returns zero on aligned 32-bit reads.

The port bus has no back-pressure. Every strobe is taken in the cycle it is presented. Read data is combinational in that cycle, and a write lands on the clock edge where the strobe is sampled high. The memory window follows the same single-cycle rule. There is no valid/ready handshake on either interface, because neither one streams data.

Top module: `sysio_regs`

## Requirements
- R1: After reset, soft_rst is 0 and le_err is 0, while map_noncontig is 1. Port 0x092 reads 0x00, port 0x81C reads 0x00 and port 0x850 reads 0x01.
- R2: A write to port 0x092 stores data bit 0 as the soft-reset flag. soft_rst shows that flag from the cycle after the write edge. A read of 0x092 returns the flag in data bit 0 and zero in all other bits.
- R3: A write to port 0x092 with data bit 1 set raises le_err on the next edge. le_err then stays high until reset. Data bit 1 is never stored, so a read of 0x092 shows it as 0.
- R4: Port 0x81C keeps only data bits 7..4 (mask 0xF0) of a write. A read returns the stored bits, with bits 3..0 reading as 0.
- R5: A write to port 0x850 stores data bit 0, and map_noncontig follows it after the edge. A read returns the flag in bit 0. The flag holds its value when there is no write to 0x850.
- R6: Ports 0x80C and 0x852 return the EQUIP_STRAP and BOARD_ID parameter values. Writes to these ports change no readable state.
- R7: Port 0x818 always reads 0x00. Writes to ports 0x808, 0x810, 0x812 and 0x814 change no state. Reads of those four ports return 0xFF.
- R8: A read of an undecoded address returns 0xFF with io_hit low. io_hit is high whenever a strobe is active on any of the ten decoded ports. When io_rd is low, io_rdata is 0xFF.
- R9: mem_hit is high for a read (mem_rd) whose address falls in the 4-byte window at WIN_BASE (0xBFFFEFF0). mem_size encodes 0 = byte, 1 = half-word, 2 = word and 3 = reserved. An aligned word read in the window gives mem_rdata 0 and mem_err 0. Any other size, or an unaligned address, gives mem_err 1 and mem_rdata all ones. Outside the window, mem_hit is 0 and mem_rdata is all ones.
- R10: Read data reflects the state before the edge in the strobe's cycle. A simultaneous read and write of one port returns the old value, and the write shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the read-strobe cycle |
| io_hit | output | 1 | Port claimed by this block |
| soft_rst | output | 1 | Soft-reset line |
| map_noncontig | output | 1 | Non-contiguous I/O map indication |
| le_err | output | 1 | Sticky unsupported-endian-mode error |
| mem_rd | input | 1 | Memory window read strobe |
| mem_addr | input | 32 | Memory address |
| mem_size | input | 2 | Access size code |
| mem_rdata | output | 32 | Memory read data |
| mem_hit | output | 1 | Window claimed |
| mem_err | output | 1 | Invalid access to the window |

## Verification
A wrong stored flag becomes visible at soft_rst or map_noncontig one cycle after the bad write edge. The same fault shows at io_rdata as soon as the port is next read. A wrong write mask or a missing store stays hidden until the port is read back, so the bench reads every live register often. A lost le_err is the easiest fault to miss, because it is sticky. It is therefore compared on every clock, not only after requests.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  localparam int NPORT = 10;

  localparam int IDX_RST    = 0;
  localparam int IDX_LED    = 1;
  localparam int IDX_EQUIP  = 2;
  localparam int IDX_PW1    = 3;
  localparam int IDX_PW2    = 4;
  localparam int IDX_L2INV  = 5;
  localparam int IDX_KEY    = 6;
  localparam int IDX_SYSCTL = 7;
  localparam int IDX_MAP    = 8;
  localparam int IDX_BRD    = 9;

  // ports that answer a read with their own value
  localparam logic [NPORT-1:0] RD_CAP = 10'h3C5;

  function automatic logic [15:0] port_addr(input int i);
    case (i)
      IDX_RST:    return 16'h0092;
      IDX_LED:    return 16'h0808;
      IDX_EQUIP:  return 16'h080C;
      IDX_PW1:    return 16'h0810;
      IDX_PW2:    return 16'h0812;
      IDX_L2INV:  return 16'h0814;
      IDX_KEY:    return 16'h0818;
      IDX_SYSCTL: return 16'h081C;
      IDX_MAP:    return 16'h0850;
      IDX_BRD:    return 16'h0852;
      default:    return 16'hFFFF;
    endcase
  endfunction

  // reversed numbering: logical bit n is data bit 7-n
  function automatic logic [7:0] lbit(input int n);
    return 8'(1) << (7 - n);
  endfunction

  localparam logic [7:0] SRST_MASK   = lbit(7);
  localparam logic [7:0] LEREQ_MASK  = lbit(6);
  localparam logic [7:0] MAP_MASK    = lbit(7);
  localparam logic [7:0] SYSCTL_MASK = lbit(0) | lbit(1) | lbit(2) | lbit(3);
endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]    addr,
  output logic [NPORT-1:0] sel
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign sel[i] = (addr == AW'(port_addr(i)));
  end
endmodule

// File: rtl/sysio_state.sv
module sysio_state
  import sysio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_rst,
  input  logic       wr_sysctl,
  input  logic       wr_map,
  input  logic [7:0] wdata,
  output logic       sreset,
  output logic [7:0] sysctl,
  output logic       map_flag,
  output logic       le_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreset   <= 1'b0;
      sysctl   <= 8'h00;
      map_flag <= 1'b1;
      le_flag  <= 1'b0;
    end else begin
      if (wr_rst) begin
        sreset <= |(wdata & SRST_MASK);
        if (|(wdata & LEREQ_MASK)) le_flag <= 1'b1;
      end
      if (wr_sysctl) sysctl   <= wdata & SYSCTL_MASK;
      if (wr_map)    map_flag <= |(wdata & MAP_MASK);
    end
  end
endmodule

// File: rtl/sysio_rmux.sv
module sysio_rmux
  import sysio_pkg::*;
#(
  parameter logic [7:0] EQUIP_STRAP = 8'h00,
  parameter logic [7:0] BOARD_ID    = 8'h00
) (
  input  logic             rd,
  input  logic [NPORT-1:0] sel,
  input  logic             sreset,
  input  logic [7:0]       sysctl,
  input  logic             map_flag,
  output logic [7:0]       rdata
);
  logic [7:0] val [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) val[i] = 8'hFF;
    val[IDX_RST]    = sreset ? SRST_MASK : 8'h00;
    val[IDX_EQUIP]  = EQUIP_STRAP;
    val[IDX_KEY]    = 8'h00;
    val[IDX_SYSCTL] = sysctl;
    val[IDX_MAP]    = map_flag ? MAP_MASK : 8'h00;
    val[IDX_BRD]    = BOARD_ID;
  end

  always_comb begin
    rdata = 8'hFF;
    if (rd) begin
      for (int i = 0; i < NPORT; i++) begin
        if (sel[i] && RD_CAP[i]) rdata = val[i];
      end
    end
  end
endmodule

// File: rtl/sysio_parwin.sv
module sysio_parwin #(
  parameter int          MAW  = 32,
  parameter logic [31:0] BASE = 32'hBFFFEFF0
) (
  input  logic           rd,
  input  logic [MAW-1:0] addr,
  input  logic [1:0]     size,
  output logic           hit,
  output logic           err,
  output logic [31:0]    rdata
);
  localparam logic [MAW-1:0] BASE_W = MAW'(BASE);
  localparam logic [1:0]     SZ_WORD = 2'd2;

  assign hit   = rd && (addr[MAW-1:2] == BASE_W[MAW-1:2]);
  assign err   = hit && ((size != SZ_WORD) || (addr[1:0] != 2'b00));
  assign rdata = (hit && !err) ? 32'h0 : 32'hFFFF_FFFF;
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
#(
  parameter int          IO_AW       = 16,
  parameter int          MEM_AW      = 32,
  parameter logic [31:0] WIN_BASE    = 32'hBFFFEFF0,
  parameter logic [7:0]  EQUIP_STRAP = 8'h00,
  parameter logic [7:0]  BOARD_ID    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_hit,
  output logic              soft_rst,
  output logic              map_noncontig,
  output logic              le_err,
  input  logic              mem_rd,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [1:0]        mem_size,
  output logic [31:0]       mem_rdata,
  output logic              mem_hit,
  output logic              mem_err
);
  logic [NPORT-1:0] sel;
  logic             sreset, map_flag, le_flag;
  logic [7:0]       sysctl;

  sysio_decode #(.AW(IO_AW)) u_dec (.addr(io_addr), .sel(sel));

  sysio_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rst    (io_wr && sel[IDX_RST]),
    .wr_sysctl (io_wr && sel[IDX_SYSCTL]),
    .wr_map    (io_wr && sel[IDX_MAP]),
    .wdata     (io_wdata),
    .sreset    (sreset),
    .sysctl    (sysctl),
    .map_flag  (map_flag),
    .le_flag   (le_flag)
  );

  sysio_rmux #(.EQUIP_STRAP(EQUIP_STRAP), .BOARD_ID(BOARD_ID)) u_rmux (
    .rd       (io_rd),
    .sel      (sel),
    .sreset   (sreset),
    .sysctl   (sysctl),
    .map_flag (map_flag),
    .rdata    (io_rdata)
  );

  sysio_parwin #(.MAW(MEM_AW), .BASE(WIN_BASE)) u_win (
    .rd    (mem_rd),
    .addr  (mem_addr),
    .size  (mem_size),
    .hit   (mem_hit),
    .err   (mem_err),
    .rdata (mem_rdata)
  );

  assign io_hit        = (io_rd || io_wr) && (|sel);
  assign soft_rst      = sreset;
  assign map_noncontig = map_flag;
  assign le_err        = le_flag;
endmodule

// File: rtl/sysio_regs_chk.sv
module sysio_regs_chk #(
  parameter int          IO_AW    = 16,
  parameter int          MEM_AW   = 32,
  parameter logic [31:0] WIN_BASE = 32'hBFFFEFF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_hit,
  input logic              soft_rst,
  input logic              map_noncontig,
  input logic              le_err,
  input logic              mem_rd,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [1:0]        mem_size,
  input logic [31:0]       mem_rdata,
  input logic              mem_err
);
  localparam logic [IO_AW-1:0] A_RST = IO_AW'(16'h0092);
  localparam logic [IO_AW-1:0] A_SYS = IO_AW'(16'h081C);
  localparam logic [IO_AW-1:0] A_MAP = IO_AW'(16'h0850);

  p_softrst_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_RST) |=> (soft_rst == $past(io_wdata[0])));

  p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_RST && io_wdata[1]) |=> le_err);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    le_err |=> le_err);

  p_sysctl_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == A_SYS) |-> (io_rdata[3:0] == 4'h0));

  p_map_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == A_MAP) |=> (map_noncontig == $past(io_wdata[0])));

  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == A_MAP) |=> $stable(map_noncontig));

  p_undecoded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_hit) |-> (io_rdata == 8'hFF));

  p_mem_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_size == 2'd2 && mem_addr == MEM_AW'(WIN_BASE))
      |-> (mem_rdata == 32'h0 && !mem_err));
endmodule

bind sysio_regs sysio_regs_chk #(.IO_AW(IO_AW), .MEM_AW(MEM_AW), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit), .soft_rst(soft_rst),
  .map_noncontig(map_noncontig), .le_err(le_err), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_rdata(mem_rdata), .mem_err(mem_err)
);

// File: tb/sysio_regs_test.sv
module sysio_regs_test;
  localparam logic [7:0]  EQ   = 8'hA5;
  localparam logic [7:0]  BD   = 8'h3C;
  localparam logic [31:0] BASE = 32'hBFFFEFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_hit, soft_rst, map_noncontig, le_err;
  logic        mem_rd = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [1:0]  mem_size = '0;
  logic [31:0] mem_rdata;
  logic        mem_hit, mem_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  bit       m_sreset, m_map, m_err;
  bit [7:0] m_sys;

  always #5 clk = ~clk;

  sysio_regs #(.EQUIP_STRAP(EQ), .BOARD_ID(BD)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit), .soft_rst(soft_rst),
    .map_noncontig(map_noncontig), .le_err(le_err), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_rdata(mem_rdata),
    .mem_hit(mem_hit), .mem_err(mem_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_port(input logic [15:0] a);
    case (a)
      16'h092, 16'h808, 16'h80C, 16'h810, 16'h812,
      16'h814, 16'h818, 16'h81C, 16'h850, 16'h852: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    case (a)
      16'h092: return {7'b0, m_sreset};
      16'h80C: return EQ;
      16'h818: return 8'h00;
      16'h81C: return m_sys;
      16'h850: return {7'b0, m_map};
      16'h852: return BD;
      default: return 8'hFF;
    endcase
  endfunction

  // one bus cycle: drive, check combinational and registered outputs, then clock the model
  task automatic cyc(input string req, input bit rd, input bit wr, input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d;
    #3;
    chk(req, "io_rdata", io_rdata, rd ? exp_read(a) : 8'hFF);
    chk(req, "io_hit", io_hit, (rd || wr) && is_port(a));
    chk(req, "soft_rst", soft_rst, m_sreset);
    chk(req, "map_noncontig", map_noncontig, m_map);
    chk(req, "le_err", le_err, m_err);
    @(posedge clk);
    if (wr) begin
      case (a)
        16'h092: begin m_sreset = d[0]; if (d[1]) m_err = 1'b1; end
        16'h81C: m_sys = d & 8'hF0;
        16'h850: m_map = d[0];
        default: ;
      endcase
    end
    #1;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic mchk(input logic [31:0] a, input logic [1:0] sz, input bit h, input bit e, input logic [31:0] d);
    mem_rd = 1'b1; mem_addr = a; mem_size = sz;
    #1;
    chk("R9", "mem_hit", mem_hit, h);
    chk("R9", "mem_err", mem_err, e);
    chk("R9", "mem_rdata", mem_rdata, d);
    mem_rd = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] tbl [12] = '{16'h092, 16'h808, 16'h80C, 16'h810, 16'h812, 16'h814,
                              16'h818, 16'h81C, 16'h850, 16'h852, 16'h093, 16'h0851};
    logic [31:0] lfsr = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_sreset = 0; m_map = 1; m_err = 0; m_sys = 8'h00;

    // R1 reset values
    cyc("R1", 1, 0, 16'h092, 0);
    cyc("R1", 1, 0, 16'h81C, 0);
    cyc("R1", 1, 0, 16'h850, 0);
    // R2 soft reset store and readback
    cyc("R2", 0, 1, 16'h092, 8'hFD);
    cyc("R2", 1, 0, 16'h092, 0);
    cyc("R2", 0, 1, 16'h092, 8'h00);
    cyc("R2", 1, 0, 16'h092, 0);
    // R3 endian request sets sticky error, not stored
    cyc("R3", 0, 1, 16'h092, 8'h02);
    cyc("R3", 1, 0, 16'h092, 0);
    cyc("R3", 0, 1, 16'h092, 8'h01);
    cyc("R3", 1, 0, 16'h092, 0);
    // R4 system control mask
    cyc("R4", 0, 1, 16'h81C, 8'hFF);
    cyc("R4", 1, 0, 16'h81C, 0);
    cyc("R4", 0, 1, 16'h81C, 8'h5A);
    cyc("R4", 1, 0, 16'h81C, 0);
    // R5 map flag
    cyc("R5", 0, 1, 16'h850, 8'hFE);
    cyc("R5", 1, 0, 16'h850, 0);
    cyc("R5", 0, 1, 16'h850, 8'h81);
    cyc("R5", 1, 0, 16'h850, 0);
    // R6 straps, writes ignored
    cyc("R6", 0, 1, 16'h80C, 8'h00);
    cyc("R6", 1, 0, 16'h80C, 0);
    cyc("R6", 0, 1, 16'h852, 8'hFF);
    cyc("R6", 1, 0, 16'h852, 0);
    // R7 keylock and write-only ports
    cyc("R7", 1, 0, 16'h818, 0);
    cyc("R7", 0, 1, 16'h808, 8'hFF);
    cyc("R7", 0, 1, 16'h810, 8'hFF);
    cyc("R7", 0, 1, 16'h812, 8'hFF);
    cyc("R7", 0, 1, 16'h814, 8'hFF);
    cyc("R7", 1, 0, 16'h808, 0);
    cyc("R7", 1, 0, 16'h092, 0);
    cyc("R7", 1, 0, 16'h81C, 0);
    cyc("R7", 1, 0, 16'h850, 0);
    // R8 undecoded addresses
    cyc("R8", 1, 0, 16'h0093, 0);
    cyc("R8", 0, 1, 16'h1092, 8'h01);
    cyc("R8", 0, 0, 16'h092, 0);
    // R10 read and write in the same cycle return old value
    cyc("R10", 1, 1, 16'h81C, 8'h30);
    cyc("R10", 1, 0, 16'h81C, 0);
    cyc("R10", 1, 1, 16'h850, 8'h01);
    cyc("R10", 1, 0, 16'h850, 0);
    // R9 parity window
    mchk(BASE, 2'd2, 1, 0, 32'h0);
    mchk(BASE, 2'd0, 1, 1, 32'hFFFF_FFFF);
    mchk(BASE, 2'd1, 1, 1, 32'hFFFF_FFFF);
    mchk(BASE + 32'd2, 2'd2, 1, 1, 32'hFFFF_FFFF);
    mchk(BASE + 32'd4, 2'd2, 0, 0, 32'hFFFF_FFFF);
    mchk(BASE - 32'd4, 2'd2, 0, 0, 32'hFFFF_FFFF);
    // R10 mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc("R10", lfsr[4], lfsr[5], tbl[lfsr[11:8] % 12], lfsr[23:16]);
    end
    // R1 reset mid-run returns to reset values
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    m_sreset = 0; m_map = 1; m_err = 0; m_sys = 8'h00;
    cyc("R1", 1, 0, 16'h092, 0);
    cyc("R1", 1, 0, 16'h850, 0);
    finish_run();
  end
endmodule